// File: doc/BRIEF.md
# Multi-Mode Timer Channel

A single timer channel with a 16-bit counter, a data (reload) register, a capture register, a timer output pin and a one-cycle interrupt. A configuration write selects one of five operating modes. The modes are periodic interval timing, input interval capture, external event counting, single-shot delay counting, and pulse-width measurement. The same write selects which edge of the input pin is active, and it sets one control bit. What that bit does depends on the mode. In interval and capture modes it asks for an interrupt and an output toggle at the moment counting starts. In single-shot mode it allows a start trigger to restart a count that is already running.

Counting advances only in cycles where the count-clock enable is high. The one exception is event mode, which counts valid pin edges instead. Software starts the channel with a start pulse and halts it with a stop pulse. Any accepted configuration write also halts the channel. The pin input must already be synchronous to the clock. Edges are detected against the pin value registered in the previous cycle.

Top module: `tmr_channel`

## Requirements
- R1: After reset the counter and capture register read 0, the timer output is 0, the interrupt is 0 and the channel is halted.
- R2: The mode codes are 000 interval, 010 capture, 011 event, 100 one-shot and 110 width. A configuration write carrying any other mode code is ignored entirely: mode, edge select and control bit are kept, and a running channel keeps running. An accepted configuration write halts the channel.
- R3: Interval mode: a start loads the data value. Each enabled cycle decrements the counter. In an enabled cycle with the counter at 0, the counter reloads the data value, the interrupt pulses and the timer output toggles. The period is therefore data+1 enabled cycles. A cycle with the enable low leaves the counter unchanged.
- R4: In interval and capture modes, a start with the control bit at 1 pulses the interrupt and toggles the timer output in the start cycle. With the bit at 0 neither happens. In event and width modes the control bit has no effect at start.
- R5: Capture mode: a start clears the counter, and each enabled cycle increments it. A valid pin edge copies the counter into the capture register, clears the counter and pulses the interrupt. An edge takes precedence over an increment in the same cycle.
- R6: The 2-bit edge select makes valid edges as follows: 00 falling only, 01 rising only, 10 and 11 both edges. Edges that are not valid have no effect.
- R7: Event mode: a start loads the data value. Each valid pin edge decrements the counter. A valid edge with the counter at 0 reloads the data value and pulses the interrupt. The count enable has no effect, and the timer output never changes in this mode.
- R8: One-shot mode: a start loads the data value, and each enabled cycle decrements the counter. In an enabled cycle with the counter at 0 the interrupt pulses and the channel halts with the counter at 0 until the next start.
- R9: One-shot mode: a start that arrives while counting is ignored when the control bit is 0. When the bit is 1 it reloads the data value. Neither case raises an interrupt.
- R10: Width mode: a start arms the channel without an interrupt. Edge select 10 measures low width: a falling edge clears the counter and starts counting, and a rising edge ends the measurement. Edge select 11 measures high width, with rising to start and falling to end. The ending edge copies the counter to the capture register, pulses the interrupt and halts the channel. A start while armed or measuring is ignored.
- R11: A stop pulse halts the channel with the counter unchanged and no interrupt. Stop takes priority over a start in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_en | input | 1 | Count-clock enable |
| start_i | input | 1 | Software start trigger |
| stop_i | input | 1 | Software stop |
| pin_i | input | 1 | External input pin (synchronous) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Mode code |
| cfg_edge | input | 2 | Edge select |
| cfg_ctl | input | 1 | Mode-dependent control bit |
| data_wr | input | 1 | Data register write strobe |
| data_in | input | CNT_W | Data register write value |
| cnt_o | output | CNT_W | Counter value |
| cap_o | output | CNT_W | Capture register |
| tout_o | output | 1 | Timer output |
| irq_o | output | 1 | Interrupt pulse |

## Verification
Every decision the channel makes becomes visible at the ports one clock after its inputs arrive, so a wrong running flag or a wrong mode register shows at once. The counter either keeps moving when it should hold, or holds when it should move. A lost measuring flag in width mode appears as a counter that is not cleared on the starting edge, or as a missing capture on the ending edge. A wrong edge-select decode shows up as a count or capture on an edge that should have been ignored. The directed scenarios read the counter after every relevant cycle, so a fault is caught within the cycle it occurs.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    M_INTV  = 3'b000,
    M_CAPT  = 3'b010,
    M_EVNT  = 3'b011,
    M_ONES  = 3'b100,
    M_WIDTH = 3'b110
  } tmr_mode_e;

  function automatic logic mode_legal(input logic [2:0] code);
    case (code)
      3'b000, 3'b010, 3'b011, 3'b100, 3'b110: mode_legal = 1'b1;
      default:                                mode_legal = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = shift_q[STAGES-1];

endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] sel_i,
  output logic       edge_v,
  output logic       edge_start,
  output logic       edge_end
);

  logic pin_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_i;
  end

  assign rise = pin_i & ~pin_q;
  assign fall = ~pin_i & pin_q;

  always_comb begin
    case (sel_i)
      2'b00:   edge_v = fall;
      2'b01:   edge_v = rise;
      default: edge_v = rise | fall;
    endcase
    // width measurement: bit 0 picks the polarity of the measured level
    edge_start = sel_i[0] ? rise : fall;
    edge_end   = sel_i[0] ? fall : rise;
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         clr,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         zero
);

  localparam logic [W-1:0] STEP = W'(1);

  logic [W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (ld)       cnt_n = ld_val;
    else if (clr) cnt_n = '0;
    else if (inc) cnt_n = cnt_q + STEP;
    else if (dec) cnt_n = cnt_q - STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt  = cnt_q;
  assign zero = (cnt_q == '0);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             pin_i,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_mode,
  input  logic [1:0]       cfg_edge,
  input  logic             cfg_ctl,
  input  logic             data_wr,
  input  logic [CNT_W-1:0] data_in,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             tout_o,
  output logic             irq_o
);

  logic rst_q_n;

  tmr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  // configuration and state registers
  tmr_mode_e        mode_q, mode_n;
  logic [1:0]       sel_q, sel_n;
  logic             ctl_q, ctl_n;
  logic [CNT_W-1:0] data_q, data_n;
  logic [CNT_W-1:0] cap_q, cap_n;
  logic             tout_q, tout_n;
  logic             irq_q, irq_n;
  logic             run_q, run_n;
  logic             meas_q, meas_n;

  logic             edge_v, edge_start, edge_end;
  logic             c_ld, c_clr, c_inc, c_dec, c_zero;
  logic [CNT_W-1:0] cnt_w;
  logic             cfg_ok, start_ok;

  tmr_edge_det u_edge (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .pin_i      (pin_i),
    .sel_i      (sel_q),
    .edge_v     (edge_v),
    .edge_start (edge_start),
    .edge_end   (edge_end)
  );

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .ld     (c_ld),
    .ld_val (data_q),
    .clr    (c_clr),
    .inc    (c_inc),
    .dec    (c_dec),
    .cnt    (cnt_w),
    .zero   (c_zero)
  );

  assign cfg_ok   = cfg_wr & mode_legal(cfg_mode);
  assign start_ok = start_i & (~run_q | ((mode_q == M_ONES) & ctl_q));

  // next-state logic
  always_comb begin
    mode_n = mode_q;
    sel_n  = sel_q;
    ctl_n  = ctl_q;
    data_n = data_in;
    if (!data_wr) data_n = data_q;
    cap_n  = cap_q;
    tout_n = tout_q;
    irq_n  = 1'b0;
    run_n  = run_q;
    meas_n = meas_q;
    c_ld   = 1'b0;
    c_clr  = 1'b0;
    c_inc  = 1'b0;
    c_dec  = 1'b0;

    if (stop_i) begin
      run_n  = 1'b0;
      meas_n = 1'b0;
    end else if (cfg_ok) begin
      mode_n = tmr_mode_e'(cfg_mode);
      sel_n  = cfg_edge;
      ctl_n  = cfg_ctl;
      run_n  = 1'b0;
      meas_n = 1'b0;
    end else if (start_ok) begin
      run_n = 1'b1;
      case (mode_q)
        M_INTV: begin
          c_ld   = 1'b1;
          irq_n  = ctl_q;
          tout_n = tout_q ^ ctl_q;
        end
        M_CAPT: begin
          c_clr  = 1'b1;
          irq_n  = ctl_q;
          tout_n = tout_q ^ ctl_q;
        end
        M_EVNT:  c_ld = 1'b1;
        M_ONES:  c_ld = 1'b1;
        default: meas_n = 1'b0;
      endcase
    end else if (run_q) begin
      case (mode_q)
        M_INTV: begin
          if (cnt_en) begin
            if (c_zero) begin
              c_ld   = 1'b1;
              irq_n  = 1'b1;
              tout_n = ~tout_q;
            end else begin
              c_dec = 1'b1;
            end
          end
        end
        M_CAPT: begin
          if (edge_v) begin
            cap_n = cnt_w;
            c_clr = 1'b1;
            irq_n = 1'b1;
          end else if (cnt_en) begin
            c_inc = 1'b1;
          end
        end
        M_EVNT: begin
          if (edge_v) begin
            if (c_zero) begin
              c_ld  = 1'b1;
              irq_n = 1'b1;
            end else begin
              c_dec = 1'b1;
            end
          end
        end
        M_ONES: begin
          if (cnt_en) begin
            if (c_zero) begin
              irq_n = 1'b1;
              run_n = 1'b0;
            end else begin
              c_dec = 1'b1;
            end
          end
        end
        default: begin
          if (!meas_q) begin
            if (edge_start) begin
              c_clr  = 1'b1;
              meas_n = 1'b1;
            end
          end else if (edge_end) begin
            cap_n  = cnt_w;
            irq_n  = 1'b1;
            run_n  = 1'b0;
            meas_n = 1'b0;
          end else if (cnt_en) begin
            c_inc = 1'b1;
          end
        end
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mode_q <= M_INTV;
      sel_q  <= 2'b00;
      ctl_q  <= 1'b0;
      data_q <= '0;
      cap_q  <= '0;
      tout_q <= 1'b0;
      irq_q  <= 1'b0;
      run_q  <= 1'b0;
      meas_q <= 1'b0;
    end else begin
      mode_q <= mode_n;
      sel_q  <= sel_n;
      ctl_q  <= ctl_n;
      data_q <= data_n;
      cap_q  <= cap_n;
      tout_q <= tout_n;
      irq_q  <= irq_n;
      run_q  <= run_n;
      meas_q <= meas_n;
    end
  end

  assign cnt_o  = cnt_w;
  assign cap_o  = cap_q;
  assign tout_o = tout_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             start_i,
  input logic             stop_i,
  input logic             cfg_wr,
  input logic [2:0]       cfg_mode,
  input logic             edge_v,
  input logic             run_q,
  input tmr_mode_e        mode_q,
  input logic             ctl_q,
  input logic [CNT_W-1:0] cnt_o,
  input logic             tout_o,
  input logic             irq_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic quiet;
  assign quiet = ~stop_i & ~cfg_wr & ~start_i;

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (cnt_o == $past(cnt_o)) && !irq_o); // R11

  AST_BAD_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !mode_legal(cfg_mode)) |=> $stable(mode_q)); // R2

  AST_EVNT_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_EVNT) |=> $stable(tout_o)); // R7

  AST_INTV_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && mode_q == M_INTV && cnt_en && cnt_o != '0 && quiet)
      |=> cnt_o == $past(cnt_o) - ONE); // R3

  AST_CAPT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && mode_q == M_CAPT && cnt_en && !edge_v && quiet)
      |=> cnt_o == $past(cnt_o) + ONE); // R5

  AST_ONES_END: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && mode_q == M_ONES && cnt_en && cnt_o == '0 && quiet)
      |=> irq_o && !run_q); // R8

  AST_WIDTH_ARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_WIDTH && start_i && !run_q && !stop_i && !cfg_wr) |=> !irq_o); // R10

  AST_START_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && start_i && !stop_i && !cfg_wr && mode_q == M_INTV && ctl_q)
      |=> irq_o && (tout_o != $past(tout_o))); // R4

endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .cnt_en   (cnt_en),
  .start_i  (start_i),
  .stop_i   (stop_i),
  .cfg_wr   (cfg_wr),
  .cfg_mode (cfg_mode),
  .edge_v   (edge_v),
  .run_q    (run_q),
  .mode_q   (mode_q),
  .ctl_q    (ctl_q),
  .cnt_o    (cnt_o),
  .tout_o   (tout_o),
  .irq_o    (irq_o)
);

// File: tb/sim_tmr_channel.sv
`timescale 1ns/1ps
module sim_tmr_channel;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n, cnt_en, start_i, stop_i, pin_i;
  logic         cfg_wr, cfg_ctl, data_wr;
  logic [2:0]   cfg_mode;
  logic [1:0]   cfg_edge;
  logic [W-1:0] data_in;
  logic [W-1:0] cnt_o, cap_o;
  logic         tout_o, irq_o;

  int checks = 0;
  int errors = 0;
  logic tref;

  always #2 clk = ~clk;

  tmr_channel #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .start_i(start_i),
    .stop_i(stop_i), .pin_i(pin_i), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cfg_edge(cfg_edge), .cfg_ctl(cfg_ctl), .data_wr(data_wr),
    .data_in(data_in), .cnt_o(cnt_o), .cap_o(cap_o), .tout_o(tout_o),
    .irq_o(irq_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] m, input logic [1:0] e, input logic c);
    cfg_wr = 1'b1; cfg_mode = m; cfg_edge = e; cfg_ctl = c;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic wdata(input logic [W-1:0] v);
    data_wr = 1'b1; data_in = v;
    tick();
    data_wr = 1'b0;
  endtask

  task automatic start();
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "cnt", cnt_o, 0);
    chk("R1", "cap", cap_o, 0);
    chk("R1", "tout", W'(tout_o), 0);
    chk("R1", "irq", W'(irq_o), 0);
    cnt_en = 1'b1;
    repeat (3) tick();
    chk("R1", "halted cnt", cnt_o, 0);
    cnt_en = 1'b0;
  endtask

  task automatic t_interval();
    wdata(3);
    cfg(3'b000, 2'b00, 1'b0);
    start();
    chk("R3", "load", cnt_o, 3);
    chk("R4", "no start irq", W'(irq_o), 0);
    chk("R4", "no start toggle", W'(tout_o), 0);
    tick();
    chk("R3", "enable low holds", cnt_o, 3);
    cnt_en = 1'b1;
    tick(); chk("R3", "dec1", cnt_o, 2);
    tick(); chk("R3", "dec2", cnt_o, 1);
    tick(); chk("R3", "dec3", cnt_o, 0);
    chk("R3", "no irq before reload", W'(irq_o), 0);
    tick();
    chk("R3", "reload", cnt_o, 3);
    chk("R3", "reload irq", W'(irq_o), 1);
    chk("R3", "reload toggle", W'(tout_o), 1);
    tick();
    chk("R3", "after reload", cnt_o, 2);
    chk("R3", "irq pulse", W'(irq_o), 0);
    stop_i = 1'b1; tick(); stop_i = 1'b0;
    chk("R11", "stop holds", cnt_o, 2);
    chk("R11", "stop no irq", W'(irq_o), 0);
    repeat (3) tick();
    chk("R11", "stopped holds", cnt_o, 2);
    cnt_en = 1'b0;
  endtask

  task automatic t_start_irq();
    cfg(3'b000, 2'b00, 1'b1);
    start();
    chk("R4", "intv start irq", W'(irq_o), 1);
    chk("R4", "intv start toggle", W'(tout_o), 0);
    chk("R4", "intv start load", cnt_o, 3);
    cfg(3'b010, 2'b01, 1'b1);
    start();
    chk("R4", "capt start irq", W'(irq_o), 1);
    chk("R4", "capt start toggle", W'(tout_o), 1);
    chk("R5", "capt start clear", cnt_o, 0);
    cfg(3'b010, 2'b01, 1'b0);
    start();
    chk("R4", "capt ctl0 no irq", W'(irq_o), 0);
    chk("R4", "capt ctl0 no toggle", W'(tout_o), 1);
  endtask

  task automatic t_capture();
    cfg(3'b010, 2'b01, 1'b0);
    start();
    cnt_en = 1'b1;
    repeat (5) tick();
    chk("R5", "count up", cnt_o, 5);
    pin_i = 1'b1; tick();
    chk("R5", "capture value", cap_o, 5);
    chk("R5", "clear on edge", cnt_o, 0);
    chk("R5", "capture irq", W'(irq_o), 1);
    tick();
    chk("R5", "resume", cnt_o, 1);
    chk("R5", "irq pulse", W'(irq_o), 0);
    pin_i = 1'b0; tick();
    chk("R6", "falling ignored cnt", cnt_o, 2);
    chk("R6", "falling ignored cap", cap_o, 5);
    chk("R6", "falling ignored irq", W'(irq_o), 0);
    cnt_en = 1'b0;
  endtask

  task automatic t_event();
    wdata(2);
    cfg(3'b011, 2'b10, 1'b1);
    tref = tout_o;
    start();
    chk("R7", "load", cnt_o, 2);
    chk("R4", "evnt ctl no irq", W'(irq_o), 0);
    chk("R4", "evnt ctl no toggle", W'(tout_o), W'(tref));
    pin_i = 1'b1; tick(); chk("R6", "both rise", cnt_o, 1);
    pin_i = 1'b0; tick(); chk("R6", "both fall", cnt_o, 0);
    pin_i = 1'b1; tick();
    chk("R7", "reload", cnt_o, 2);
    chk("R7", "irq", W'(irq_o), 1);
    chk("R7", "no toggle", W'(tout_o), W'(tref));
    cnt_en = 1'b1;
    repeat (3) tick();
    chk("R7", "enable no effect", cnt_o, 2);
    cnt_en = 1'b0;
    cfg(3'b011, 2'b00, 1'b0);
    start();
    pin_i = 1'b0; tick(); chk("R6", "falling counts", cnt_o, 1);
    pin_i = 1'b1; tick(); chk("R6", "rising ignored", cnt_o, 1);
    cfg_wr = 1'b1; cfg_mode = 3'b111; cfg_edge = 2'b01; cfg_ctl = 1'b1;
    tick(); cfg_wr = 1'b0;
    pin_i = 1'b0; tick();
    chk("R2", "bad code ignored", cnt_o, 0);
    cfg(3'b011, 2'b00, 1'b0);
    pin_i = 1'b1; tick();
    pin_i = 1'b0; tick();
    chk("R2", "legal write halts", cnt_o, 0);
    chk("R2", "halted no irq", W'(irq_o), 0);
  endtask

  task automatic t_oneshot();
    wdata(4);
    cfg(3'b100, 2'b00, 1'b0);
    cnt_en = 1'b1;
    start();
    chk("R8", "load", cnt_o, 4);
    repeat (4) tick();
    chk("R8", "reached zero", cnt_o, 0);
    chk("R8", "no early irq", W'(irq_o), 0);
    tick();
    chk("R8", "end irq", W'(irq_o), 1);
    chk("R8", "end cnt", cnt_o, 0);
    tick();
    chk("R8", "halted", cnt_o, 0);
    chk("R8", "single irq", W'(irq_o), 0);
    start(); tick();
    chk("R8", "restart", cnt_o, 3);
    start();
    chk("R9", "retrigger off ignored", cnt_o, 2);
    chk("R9", "retrigger off no irq", W'(irq_o), 0);
    cfg(3'b100, 2'b00, 1'b1);
    start(); tick(); tick();
    chk("R9", "before retrigger", cnt_o, 2);
    start();
    chk("R9", "retrigger reloads", cnt_o, 4);
    chk("R9", "retrigger no irq", W'(irq_o), 0);
    tick();
    chk("R9", "continues", cnt_o, 3);
    cnt_en = 1'b0;
  endtask

  task automatic t_width();
    cfg(3'b110, 2'b10, 1'b0);
    pin_i = 1'b1; tick();
    cnt_en = 1'b1;
    start();
    chk("R10", "arm no irq", W'(irq_o), 0);
    tick(); tick();
    pin_i = 1'b0; tick();
    chk("R10", "start edge clears", cnt_o, 0);
    repeat (3) tick();
    chk("R10", "low count", cnt_o, 3);
    start();
    chk("R10", "start ignored", cnt_o, 4);
    chk("R10", "start ignored irq", W'(irq_o), 0);
    pin_i = 1'b1; tick();
    chk("R10", "low capture", cap_o, 4);
    chk("R10", "end irq", W'(irq_o), 1);
    tick();
    chk("R10", "halted", cnt_o, 4);
    cfg(3'b110, 2'b11, 1'b0);
    start();
    pin_i = 1'b0; tick();
    chk("R10", "falling not start", cnt_o, 4);
    chk("R10", "no capture unarmed", cap_o, 4);
    pin_i = 1'b1; tick();
    chk("R10", "rising starts", cnt_o, 0);
    tick(); tick();
    pin_i = 1'b0; tick();
    chk("R10", "high capture", cap_o, 2);
    chk("R10", "high end irq", W'(irq_o), 1);
    cnt_en = 1'b0;
  endtask

  task automatic t_stop();
    wdata(5);
    cfg(3'b000, 2'b00, 1'b0);
    cnt_en = 1'b1;
    stop_i = 1'b1; start_i = 1'b1; tick();
    stop_i = 1'b0; start_i = 1'b0;
    chk("R11", "stop beats start", cnt_o, 2);
    tick(); tick();
    chk("R11", "still halted", cnt_o, 2);
    start(); tick();
    chk("R11", "running", cnt_o, 4);
    stop_i = 1'b1; tick(); stop_i = 1'b0;
    chk("R11", "stop freeze", cnt_o, 4);
    tick();
    chk("R11", "frozen", cnt_o, 4);
    cnt_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_en = 1'b0; start_i = 1'b0; stop_i = 1'b0;
    pin_i = 1'b0; cfg_wr = 1'b0; cfg_mode = 3'b000; cfg_edge = 2'b00;
    cfg_ctl = 1'b0; data_wr = 1'b0; data_in = '0;
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    t_reset();
    t_interval();
    t_start_irq();
    t_capture();
    t_event();
    t_oneshot();
    t_width();
    t_stop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule